// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of general-purpose input pins and turns selected signal transitions into interrupt requests. Every pin first passes through a synchroniser. It is then compared with its own value one clock earlier. Two enable masks choose, per pin, whether a low-to-high transition, a high-to-low transition, both, or neither is of interest. A qualifying transition sets that pin's bit in a sticky status word. Software clears the bit by writing a one to it.

The low pins each have a dedicated request line that follows their status bit. The remaining upper pins share one request line, which is the OR of their status bits. Software that sees the shared line reads the status word to find which upper pin fired. All configuration and status access goes through a small synchronous register port. The port has an address, a write strobe, write data and combinational read data.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the rise-enable mask, the fall-enable mask and the status word are all zero, and every request output is low.
- R2: Register addresses: 0 holds the rise-enable mask, 1 holds the fall-enable mask, 2 holds the status word. In each register, bit i belongs to pin i. A write at address 0 or 1 replaces the whole mask, and reading the address returns it.
- R3: With its rise-enable bit set, a 0-to-1 change on pin i sets status bit i. The new value is visible after the third rising clock edge that follows the pin change, and not after the second.
- R4: With its fall-enable bit set, a 1-to-0 change on pin i sets status bit i, with the same latency as R3.
- R5: With both enable bits set, a pin reports transitions in either direction. With neither bit set, it reports no transition.
- R6: Writing to address 2 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value, and writing all ones clears every pending bit.
- R7: If a qualifying transition on pin i and a write that clears bit i take effect on the same clock edge, bit i ends up set.
- R8: Clearing an enable bit does not remove a status bit that is already latched.
- R9: Request output irq_direct[i], for i below the direct-pin count (11 by default), equals status bit i.
- R10: irq_shared is high exactly when at least one status bit at or above the direct-pin count is set.
- R11: A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS (28) | Asynchronous pin levels |
| bus_addr | input | ADDR_W (2) | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | NUM_PINS (28) | Write data |
| bus_rdata | output | NUM_PINS (28) | Read data for bus_addr, combinational |
| irq_direct | output | NUM_DIRECT (11) | Per-pin request lines for the low pins |
| irq_shared | output | 1 | OR of the status bits of the upper pins |

## Verification
The bench sweeps every pin through all four enable combinations and drives a rising and then a falling transition. It checks the status word and both request outputs against values built from the pin index. This catches a swapped edge polarity, an off-by-one split between the direct and shared pins, and a shared line that misses its top pin. The status word is also read one cycle before it should change, so a design with a missing or extra synchroniser stage shows the wrong latency. The bench lines up a clear write with the edge that an incoming transition takes effect on. A design that lets the clear win would lose that event. Writing zero to status bits and turning an enable off while a bit is latched both leave that bit set; a design that treated either as a clear would drop a pending request.

// File: rtl/gei_pkg.sv
package gei_pkg;
    // Register map of the edge-detect unit
    localparam int unsigned ADDR_RISE   = 0;
    localparam int unsigned ADDR_FALL   = 1;
    localparam int unsigned ADDR_STATUS = 2;
endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
    parameter int unsigned W      = 28,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/gei_edge.sv
module gei_edge #(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] en_rise_i,
    input  logic [W-1:0] en_fall_i,
    output logic [W-1:0] evt_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_t;

    edge_t st_d, st_q;
    logic [W-1:0] rose, fell;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rose      = level_i & ~st_q.prev;
        fell      = ~level_i & st_q.prev;
        evt_o     = (rose & en_rise_i) | (fell & en_fall_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // An event on a pin means its level moved since the last clock
    assert_evt_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o & ~(level_i ^ st_q.prev)) == '0);
endmodule

// File: rtl/gei_regs.sv
module gei_regs
    import gei_pkg::*;
#(
    parameter int unsigned W      = 28,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      evt_i,
    output logic [W-1:0]      rdata_o,
    output logic [W-1:0]      en_rise_o,
    output logic [W-1:0]      en_fall_o,
    output logic [W-1:0]      status_o
);
    localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(ADDR_RISE);
    localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(ADDR_FALL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);

    typedef struct packed {
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] status;
    } regs_t;

    regs_t st_d, st_q;
    logic hit_rise, hit_fall, hit_stat;
    logic [W-1:0] clr_mask;

    always_comb begin
        hit_rise = wr_i && (addr_i == A_RISE);
        hit_fall = wr_i && (addr_i == A_FALL);
        hit_stat = wr_i && (addr_i == A_STAT);
        clr_mask = hit_stat ? wdata_i : '0;
        st_d = st_q;
        if (hit_rise) st_d.rise = wdata_i;
        if (hit_fall) st_d.fall = wdata_i;
        // a fresh event outranks a simultaneous clear
        st_d.status = (st_q.status & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr_i)
            A_RISE:  rdata_o = st_q.rise;
            A_FALL:  rdata_o = st_q.fall;
            A_STAT:  rdata_o = st_q.status;
            default: rdata_o = '0;
        endcase
    end

    assign en_rise_o = st_q.rise;
    assign en_fall_o = st_q.fall;
    assign status_o  = st_q.status;

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (addr_i == A_RISE)) |=> $stable(st_q.rise));
    assert_set_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status & ~$past(st_q.status) & ~$past(evt_i)) == '0));
    assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_STAT && wdata_i == '1 && evt_i == '0) |=> (st_q.status == '0));
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_i) & ~st_q.status) == '0));
    assert_no_clear_elsewhere_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == A_STAT) |=> ((~st_q.status & $past(st_q.status)) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int unsigned NUM_PINS    = 28,
    parameter int unsigned NUM_DIRECT  = 11,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    output logic [NUM_PINS-1:0]   bus_rdata,
    output logic [NUM_DIRECT-1:0] irq_direct,
    output logic                  irq_shared
);
    localparam int unsigned NUM_SHARED = NUM_PINS - NUM_DIRECT;

    logic [NUM_PINS-1:0] level, evt, en_rise, en_fall, status;

    gei_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(level));

    gei_edge #(.W(NUM_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(level),
        .en_rise_i(en_rise), .en_fall_i(en_fall), .evt_o(evt));

    gei_regs #(.W(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .evt_i(evt), .rdata_o(bus_rdata),
        .en_rise_o(en_rise), .en_fall_o(en_fall), .status_o(status));

    assign irq_direct = status[NUM_DIRECT-1:0];

    generate
        if (NUM_SHARED > 0) begin : g_shared
            assign irq_shared = |status[NUM_PINS-1:NUM_DIRECT];
        end else begin : g_no_shared
            assign irq_shared = 1'b0;
        end
    endgenerate

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_direct == '0 && !irq_shared));
    assert_direct_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[NUM_DIRECT-1:0] != '0) |=> (irq_direct != '0));
    assert_shared_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[NUM_PINS-1:NUM_DIRECT] != '0) |=> irq_shared);
endmodule

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
    localparam int NP = 28;
    localparam int ND = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic [1:0]    addr = '0;
    logic          wr = 1'b0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic [ND-1:0] irq_direct;
    logic          irq_shared;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_edge_irq u_gpio_edge_irq (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_direct(irq_direct), .irq_shared(irq_shared));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [NP-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [NP-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_irqs(input string req, input logic [NP-1:0] st);
        chk(req, {21'b0, irq_direct}, {21'b0, st[ND-1:0]});
        chk(req, {31'b0, irq_shared}, {31'b0, |st[NP-1:ND]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] r;
        logic [NP-1:0] bit_p;
        logic [NP-1:0] exp;
        repeat (3) @(negedge clk);
        // R1 reset state
        bus_read(0, r); chk("R1 rise mask", 32'(r), 0);
        bus_read(1, r); chk("R1 fall mask", 32'(r), 0);
        bus_read(2, r); chk("R1 status", 32'(r), 0);
        check_irqs("R1 irq", '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 mask read-back
        bus_write(0, 28'h5A5_1234);
        bus_write(1, 28'hA5A_4321);
        bus_read(0, r); chk("R2 rise readback", 32'(r), 32'h05A5_1234);
        bus_read(1, r); chk("R2 fall readback", 32'(r), 32'h0A5A_4321);
        // R11 unmapped address
        bus_read(3, r); chk("R11 unmapped read", 32'(r), 0);

        // R3 R4 R5 R9 R10 sweep: every pin, every enable combination
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 4; m++) begin
                bit_p = NP'(1) << p;
                bus_write(0, m[0] ? bit_p : '0);
                bus_write(1, m[1] ? bit_p : '0);
                bus_write(2, '1);
                pins[p] = 1'b1;
                repeat (2) @(negedge clk);
                bus_read(2, r); chk("R3 latency early", 32'(r), 0);
                @(negedge clk);
                exp = m[0] ? bit_p : '0;
                bus_read(2, r); chk(m[0] ? "R3 rise" : "R5 rise ignored", 32'(r), 32'(exp));
                check_irqs("R9 R10 after rise", exp);
                bus_write(2, '1);
                bus_read(2, r); chk("R6 clear all", 32'(r), 0);
                pins[p] = 1'b0;
                repeat (3) @(negedge clk);
                exp = m[1] ? bit_p : '0;
                bus_read(2, r); chk(m[1] ? "R4 fall" : "R5 fall ignored", 32'(r), 32'(exp));
                check_irqs("R9 R10 after fall", exp);
                bus_write(2, '1);
            end
        end

        // R6 write of zero keeps bits; partial clear
        bus_write(0, 28'h000_0811);
        bus_write(1, '0);
        pins = 28'h000_0811;
        repeat (3) @(negedge clk);
        bus_read(2, r); chk("R5 multi pin", 32'(r), 32'h0000_0811);
        bus_write(2, '0);
        bus_read(2, r); chk("R6 zero write", 32'(r), 32'h0000_0811);
        bus_write(2, 28'h000_0001);
        bus_read(2, r); chk("R6 partial clear", 32'(r), 32'h0000_0810);
        check_irqs("R10 shared only upper", 28'h000_0810);

        // R8 disabling the enable keeps the latched bit
        bus_write(0, '0);
        bus_read(2, r); chk("R8 latched after disable", 32'(r), 32'h0000_0810);
        bus_write(2, '1);
        pins = '0;
        repeat (3) @(negedge clk);

        // R7 clear coincides with an event on the same pin
        bus_write(0, 28'h000_0004);
        pins[2] = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(2, r); chk("R7 setup", 32'(r), 32'h0000_0004);
        bus_write(1, 28'h000_0004);
        pins[2] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_write(2, 28'h000_0004);
        bus_read(2, r); chk("R7 event wins", 32'(r), 32'h0000_0004);
        bus_write(2, 28'h000_0004);
        bus_read(2, r); chk("R7 later clear", 32'(r), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule